// File: doc/BRIEF.md
# Programmable High/Low Phase Clock Divider

The block derives an output clock from a reference clock. A control word holds a divide-enable bit and two independent phase counts, one for the high phase and one for the low phase, so both ratio and duty cycle are programmable. With divide disabled, the reference clock passes straight through. A separate gate register switches the output on and off. A build parameter can mark the clock as always on, and the gate then has no effect.

Software reaches both registers through a small synchronous port made of a strobe, a write flag, a one-bit address and write and read data, all clocked by the reference clock. Reconfiguration is glitch free. New phase counts take effect only at the end of the running period. A change of mode or gate is applied on a falling reference edge, and only while the selected source is low.

Top module: `phase_clk_div`

## Requirements
- R1: With the divide-enable bit (control bit 0) clear, `clk_o` follows `clk_ref` (high in the high half, low in the low half) whatever the phase fields hold.
- R2: With the divide-enable bit set, `clk_o` is high for (H+1) and then low for (L+1) reference cycles, where H is control bits [HI_W:1] and L is control bits [HI_W+LO_W:HI_W+1].
- R3: A zero phase field gives a one-cycle phase, so H=L=0 gives the smallest ratio, a period of 2 reference cycles.
- R4: Phase counts written while dividing leave the running period unchanged and apply from the next rising output edge.
- R5: Gate register bit 0 set lets the clock out. Clear forces `clk_o` low.
- R6: With ALWAYS_ON=1, writes to the gate register have no effect, the output is never gated, and the gate register reads 1.
- R7: After reset the block is in bypass, the phase fields are zero, the gate is off (unless ALWAYS_ON), both registers read 0, and `clk_o` stays low.
- R8: A read (strobe high, write flag low) returns, one cycle later on `cfg_rdata`, the last value written: address 0 gives the control word, address 1 gives the gate bit in bit 0.
- R9: Mode and gate changes take effect only while the output is low: a high phase that is running when bypass is requested completes its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sel | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 1 | 0 = control word, 1 = gate |
| cfg_wdata | input | 1+HI_W+LO_W | Write data |
| cfg_rdata | output | 1+HI_W+LO_W | Registered read data |
| clk_o | output | 1 | Divided, bypassed or gated output clock |

## Verification
The bench measures high and low run lengths over ratios from 2 (both fields zero) up to the widest fields and over lopsided duty cycles. A design with an off-by-one phase count, or with swapped high and low fields, shows up there. It rewrites the phase counts in the middle of a period. A design that applies them at once cuts the running high phase short. It requests bypass during a long high phase. A design that switches at once gives a truncated pulse that the falling-edge samples catch. Gating is checked on a normal instance and on an always-on instance, so a gate that ignores the always-on parameter, or a gate that leaks, is reported.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_GATE = 1'b1
  } cdiv_addr_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 4,
  parameter bit ALWAYS_ON = 1'b0,
  localparam int CTRL_W = 1 + HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic              gate
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_n, rdata_q, rdata_n;
  logic              ctrl_we, rd_en;

  assign ctrl_we = sel && wr && (cdiv_addr_e'(addr) == REG_CTRL);
  assign rd_en   = sel && !wr;

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_we) ctrl_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  generate
    if (ALWAYS_ON) begin : g_gate_fixed
      assign gate = 1'b1;
    end else begin : g_gate_reg
      logic gate_q, gate_n, gate_we;
      assign gate_we = sel && wr && (cdiv_addr_e'(addr) == REG_GATE);
      always_comb begin
        gate_n = gate_q;
        if (gate_we) gate_n = wdata[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_n;
      end
      assign gate = gate_q;
    end
  endgenerate

  always_comb begin
    rdata_n = rdata_q;
    if (rd_en) begin
      if (cdiv_addr_e'(addr) == REG_CTRL) rdata_n = ctrl_q;
      else                                rdata_n = {{(CTRL_W-1){1'b0}}, gate};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;
  assign ctrl  = ctrl_q;

  // R8: a control read returns the word held when the strobe was sampled
  p_read_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cdiv_addr_e'(addr) == REG_CTRL) |=> (rdata == $past(ctrl_q)));
endmodule

// File: rtl/cdiv_phase_ctr.sv
module cdiv_phase_ctr
  import cdiv_pkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 4,
  localparam int CW = imax(HI_W, LO_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HI_W-1:0] hi_cfg,
  input  logic [LO_W-1:0] lo_cfg,
  output logic            div_q
);
  logic [HI_W-1:0] hi_act, hi_n;
  logic [LO_W-1:0] lo_act, lo_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            div_n;
  logic            hi_end, lo_end;

  assign hi_end = (cnt_q == CW'(hi_act));
  assign lo_end = (cnt_q == CW'(lo_act));

  always_comb begin
    div_n = div_q;
    cnt_n = cnt_q;
    hi_n  = hi_act;
    lo_n  = lo_act;
    if (!run) begin
      div_n = 1'b0;
      hi_n  = hi_cfg;
      lo_n  = lo_cfg;
      cnt_n = CW'(lo_cfg);
    end else if (div_q) begin
      if (hi_end) begin
        div_n = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else begin
      if (lo_end) begin
        div_n = 1'b1;
        cnt_n = '0;
        hi_n  = hi_cfg;
        lo_n  = lo_cfg;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      cnt_q  <= '0;
      hi_act <= '0;
      lo_act <= '0;
    end else begin
      div_q  <= div_n;
      cnt_q  <= cnt_n;
      hi_act <= hi_n;
      lo_act <= lo_n;
    end
  end

  // R1: bypass keeps the divided waveform parked low
  p_bypass_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !div_q);
  // R2: the phase counter never passes the applied phase length
  p_hi_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_q) |-> (cnt_q <= CW'(hi_act)));
  p_lo_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div_q) |-> (cnt_q <= CW'(lo_act)));
  // R4: applied phase lengths are frozen during a running high phase
  p_hold_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_q) |=> ($stable(hi_act) && $stable(lo_act)));
endmodule

// File: rtl/cdiv_out_sel.sv
module cdiv_out_sel #(
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en_cfg,
  input  logic gate_cfg,
  input  logic div_q,
  output logic run,
  output logic clk_o
);
  logic mode_act, mode_n, gate_act, gate_n;
  logic apply_ok;

  // On a falling reference edge the reference is low; the divided source
  // must be low as well before either selection may move.
  assign apply_ok = !div_q;

  always_comb begin
    mode_n = mode_act;
    gate_n = gate_act;
    if (apply_ok) begin
      mode_n = div_en_cfg;
      gate_n = gate_cfg;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_act <= 1'b0;
      gate_act <= ALWAYS_ON;
    end else begin
      mode_act <= mode_n;
      gate_act <= gate_n;
    end
  end

  assign run   = mode_act;
  assign clk_o = gate_act & (mode_act ? div_q : clk);

  // R9: a selection change is only ever seen while the divided source is low
  p_switch_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_act != $past(mode_act)) || (gate_act != $past(gate_act))) |-> !div_q);

  generate
    if (ALWAYS_ON) begin : g_on_chk
      // R6: an always-on clock is never gated
      p_never_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_act);
    end
  endgenerate
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div #(
  parameter int HI_W = 4,
  parameter int LO_W = 4,
  parameter bit ALWAYS_ON = 1'b0,
  localparam int CTRL_W = 1 + HI_W + LO_W
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              clk_o
);
  localparam int HI_LSB = 1;
  localparam int LO_LSB = HI_LSB + HI_W;

  logic              rst_sn;
  logic [CTRL_W-1:0] ctrl;
  logic              gate;
  logic              run;
  logic              div_q;

  cdiv_rst_sync u_rst (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  cdiv_regs #(.HI_W(HI_W), .LO_W(LO_W), .ALWAYS_ON(ALWAYS_ON)) u_regs (
    .clk  (clk_ref),
    .rst_n(rst_sn),
    .sel  (cfg_sel),
    .wr   (cfg_wr),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .ctrl (ctrl),
    .gate (gate)
  );

  cdiv_phase_ctr #(.HI_W(HI_W), .LO_W(LO_W)) u_ctr (
    .clk   (clk_ref),
    .rst_n (rst_sn),
    .run   (run),
    .hi_cfg(ctrl[LO_LSB-1:HI_LSB]),
    .lo_cfg(ctrl[CTRL_W-1:LO_LSB]),
    .div_q (div_q)
  );

  cdiv_out_sel #(.ALWAYS_ON(ALWAYS_ON)) u_sel (
    .clk       (clk_ref),
    .rst_n     (rst_sn),
    .div_en_cfg(ctrl[0]),
    .gate_cfg  (gate),
    .div_q     (div_q),
    .run       (run),
    .clk_o     (clk_o)
  );
endmodule

// File: tb/phase_clk_div_tb_top.sv
module phase_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HI_W = 4;
  localparam int LO_W = 4;
  localparam int CW = 1 + HI_W + LO_W;
  localparam int NVEC = 7;
  // each entry: {high field, low field}
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'h10, 8'h01, 8'h32, 8'hFF, 8'h70, 8'h29};

  logic clk_ref = 1'b0;
  logic rst_n;
  logic cfg_sel, cfg_wr, cfg_addr;
  logic [CW-1:0] cfg_wdata, cfg_rdata, rdata_on;
  logic clk_o, clk_on;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  phase_clk_div #(.HI_W(HI_W), .LO_W(LO_W), .ALWAYS_ON(1'b0)) dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clk_o(clk_o));

  phase_clk_div #(.HI_W(HI_W), .LO_W(LO_W), .ALWAYS_ON(1'b1)) dut_on_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_on), .clk_o(clk_on));

  function automatic logic [CW-1:0] mk(input logic en, input int hi, input int lo);
    return {LO_W'(lo), HI_W'(hi), en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_hi(output logic v);
    @(posedge clk_ref); #2;
    v = clk_o;
    cfg_sel = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic tick_lo(output logic v);
    @(negedge clk_ref); #2;
    v = clk_o;
  endtask

  task automatic cfg_write(input logic a, input logic [CW-1:0] d);
    cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk_ref); #2;
    cfg_sel = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic a, output int d, output int d_on);
    cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
    @(posedge clk_ref); #2;
    cfg_sel = 1'b0;
    d = int'(cfg_rdata); d_on = int'(rdata_on);
  endtask

  task automatic wait_ticks(input int n);
    logic v;
    for (int i = 0; i < n; i++) tick_hi(v);
  endtask

  task automatic sync_rise(output bit ok);
    logic prev, cur;
    ok = 1'b0;
    tick_hi(prev);
    for (int i = 0; i < 200; i++) begin
      tick_hi(cur);
      if (!prev && cur) begin ok = 1'b1; break; end
      prev = cur;
    end
  endtask

  task automatic measure(output int h, output int l);
    logic cur;
    h = 1; l = 0;
    for (int i = 0; i < 100; i++) begin
      tick_hi(cur);
      if (cur) h++; else begin l = 1; break; end
    end
    for (int i = 0; i < 100; i++) begin
      tick_hi(cur);
      if (!cur) l++; else break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h, l, d, d_on, ones, ones_on, hruns;
    logic v;
    bit ok;
    rst_n = 1'b0; cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    repeat (3) @(posedge clk_ref);
    #2 rst_n = 1'b1;
    wait_ticks(4);

    // R7: reset state
    tick_hi(v); chk("R7 clk_o low after reset", int'(v), 0);
    chk("R6 always-on runs after reset", int'(clk_on), 1);
    cfg_read(1'b0, d, d_on); chk("R7 ctrl reads zero", d, 0);
    cfg_read(1'b1, d, d_on); chk("R7 gate reads zero", d, 0);
    chk("R6 always-on gate reads one", d_on, 1);

    // R1: bypass, fields ignored
    cfg_write(1'b1, CW'(1));
    wait_ticks(3);
    tick_hi(v); chk("R1 bypass high half", int'(v), 1);
    tick_lo(v); chk("R1 bypass low half", int'(v), 0);
    cfg_write(1'b0, mk(1'b0, 5, 3));
    wait_ticks(6);
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      tick_hi(v); ones += int'(v);
      tick_lo(v); ones += 2 * int'(v);
    end
    chk("R1 bypass ignores fields", ones, 8);
    cfg_read(1'b0, d, d_on); chk("R8 ctrl readback", d, int'(mk(1'b0, 5, 3)));
    cfg_read(1'b1, d, d_on); chk("R8 gate readback", d, 1);

    // R2 / R3: table of phase settings
    for (int k = 0; k < NVEC; k++) begin
      int hi_f, lo_f;
      hi_f = int'(VEC[k][7:4]); lo_f = int'(VEC[k][3:0]);
      cfg_write(1'b0, mk(1'b1, hi_f, lo_f));
      sync_rise(ok); chk("R2 rise found", int'(ok), 1);
      measure(h, l);
      chk("R2 high run", h, hi_f + 1);
      chk("R2 low run", l, lo_f + 1);
      if (hi_f == 0 && lo_f == 0) chk("R3 minimum period", h + l, 2);
      cfg_read(1'b0, d, d_on); chk("R8 ctrl readback vec", d, int'(mk(1'b1, hi_f, lo_f)));
    end

    // R4: mid-period change
    cfg_write(1'b0, mk(1'b1, 5, 3));
    sync_rise(ok);
    measure(h, l);
    cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = mk(1'b1, 1, 2);
    measure(h, l);
    chk("R4 running high kept", h, 6);
    chk("R4 running low kept", l, 4);
    measure(h, l);
    chk("R4 new high applied", h, 2);
    chk("R4 new low applied", l, 3);

    // R9: bypass request mid high phase
    cfg_write(1'b0, mk(1'b1, 5, 3));
    sync_rise(ok);
    measure(h, l);
    cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = mk(1'b0, 5, 3);
    hruns = 0;
    for (int i = 0; i < 12; i++) begin
      tick_lo(v);
      if (i == 1) begin cfg_sel = 1'b0; cfg_wr = 1'b0; end
      if (v && hruns == i) hruns++;
    end
    chk("R9 high phase completes", hruns, 6);
    wait_ticks(4);
    tick_hi(v); chk("R1 bypass after switch high", int'(v), 1);
    tick_lo(v); chk("R1 bypass after switch low", int'(v), 0);

    // R5 / R6: gating
    cfg_write(1'b0, mk(1'b1, 2, 1));
    wait_ticks(10);
    cfg_write(1'b1, CW'(0));
    wait_ticks(10);
    ones = 0; ones_on = 0;
    for (int i = 0; i < 20; i++) begin
      tick_hi(v); ones += int'(v); ones_on += int'(clk_on);
      tick_lo(v); ones += int'(v);
    end
    chk("R5 gated output held low", ones, 0);
    chk("R6 always-on not gated", int'(ones_on > 0), 1);
    cfg_read(1'b1, d, d_on);
    chk("R8 gate readback zero", d, 0);
    chk("R6 always-on gate still one", d_on, 1);
    cfg_write(1'b1, CW'(1));
    sync_rise(ok);
    measure(h, l);
    chk("R5 ungated high run", h, 3);
    chk("R5 ungated low run", l, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule